// File: doc/BRIEF.md
# Descriptor-Driven Configuration DMA Engine

This block moves configuration item data into system memory without byte-by-byte programmed reads. Software first stores a 16-byte descriptor in memory. It then writes the descriptor's 64-bit address into a big-endian address register, which is exposed as two 32-bit halves. Writing the low half launches the work. The engine reads the descriptor through a word-wide memory master port and can switch the selected configuration item. It then either copies bytes of that item to a target address or moves the item's read offset forward without copying. It finishes by rewriting the descriptor's control word with a status value.

The engine has no item storage of its own. It drives the current item key and byte offset of the neighbouring configuration port through a sideband. The port returns the current item's length and the byte at the current offset. A selection and an offset change take effect at the clock edge on which the engine requests them. Memory transactions are held until an acknowledge arrives, and the acknowledge can carry an error flag.

Top module: `cfg_dma_engine`

## Requirements
- R1: After reset, `busy` is low, no memory request is issued, and `reg_rdata` returns the signature 64'h51454D5520434647 whenever the engine is idle.
- R2: A write with `reg_wr_low`=0 stores bits 63:32 of the descriptor address and starts nothing. A write with `reg_wr_low`=1 stores bits 31:0 and starts an operation. The descriptor is then fetched as four word reads at the descriptor address plus 0, 4, 8 and 12, using the stored upper half.
- R3: While busy, `reg_rdata` returns the descriptor address. After completion the address register is zero, so a later launch that writes only the low half fetches with upper address bits of zero.
- R4: Memory words are big-endian: bits 31:24 hold the byte at the lowest address. The descriptor holds, in order, a control word, a byte length, the upper target-address word and the lower target-address word.
- R5: If control bit 3 is set, the item key becomes control bits 31:16 and the offset becomes zero before any transfer.
- R6: If control bit 1 is set, `length` bytes are written to target+i, each taken from the item at the starting offset plus i. The offset advances once per byte written.
- R7: A byte whose offset is at or past the item length is written as 8'h00, and the offset stops at the item length.
- R8: If control bit 2 is set and bit 1 is clear, the offset becomes min(offset+length, item length), and no memory write other than the status write is issued.
- R9: If neither bit 1 nor bit 2 is set, only the optional selection happens and the status reports success.
- R10: On completion the control word at the descriptor address is written with a full-word strobe as 32'h0 for success, then `busy` falls.
- R11: An error response during fetch or copy ends the operation and writes the status 32'h1. An error response on the status write itself ends the operation with nothing further written.
- R12: Register writes of either half that arrive while busy are ignored and start no further operation.
- R13: A memory request stays asserted with a stable address and direction until it is acknowledged.
- R14: Each copied byte is written with a single strobe bit, 3 minus address bits 1:0, and neighbouring bytes keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Address register write strobe |
| reg_wr_low | input | 1 | 1 selects the low half (launch), 0 the high half |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 64 | Signature when idle, descriptor address when busy |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 64 | Byte address of the request |
| mem_wdata | output | 32 | Write data, big-endian lanes |
| mem_wstrb | output | 4 | Byte strobes, bit 3 is the lowest address |
| mem_ack | input | 1 | Request completed |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| sel_we | output | 1 | Load a new item key and zero the offset |
| sel_key | output | 16 | New item key |
| off_we | output | 1 | Load a new offset |
| off_next | output | 32 | New offset value |
| item_off | input | 32 | Current item offset |
| item_len | input | 32 | Length of the current item |
| item_byte | input | 8 | Item byte at the current offset |

## Verification
Every cycle, the assertions check that held requests do not change, that a copy write carries exactly one strobe, and that a status write carries only bit 0. They also check that the offset never passes the item length, that no memory write occurs outside copy and status phases, that busy-time register writes leave the address unchanged, and that the register clears on completion. Only the bench scenarios can show that copied bytes match the item contents at each alignment and starting offset. The same holds for zero fill past the end, skip saturation, the status value left in memory after each kind of error, and the upper address half being clear on the next single-write launch.

// File: rtl/cfg_dma_pkg.sv
`timescale 1ns/1ps
package cfg_dma_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_SEL, S_DISP, S_COPY, S_WB
  } dma_st_e;

  localparam logic [63:0] DMA_SIGNATURE = 64'h5145_4D55_2043_4647;

  localparam int CB_READ = 1;
  localparam int CB_SKIP = 2;
  localparam int CB_SEL  = 3;
endpackage

// File: rtl/cfg_dma_regs.sv
`timescale 1ns/1ps
module cfg_dma_regs #(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_low,
  input  logic [DW-1:0]     wdata,
  input  logic              done,
  output logic              start,
  output logic              busy,
  output logic [2*DW-1:0]   desc_addr,
  output logic [2*DW-1:0]   rdata
);
  import cfg_dma_pkg::*;
  localparam int AW = 2 * DW;

  logic [AW-1:0] addr_q, addr_d;
  logic          busy_q, busy_d;
  logic          accept;

  assign accept = wr_en & ~busy_q;
  assign start  = accept & wr_low;

  always_comb begin
    addr_d = addr_q;
    busy_d = busy_q;
    if (done) begin
      addr_d = '0;
      busy_d = 1'b0;
    end else if (accept) begin
      if (wr_low) begin
        addr_d[DW-1:0] = wdata;
        busy_d         = 1'b1;
      end else begin
        addr_d[AW-1:DW] = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      busy_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      busy_q <= busy_d;
    end
  end

  assign busy      = busy_q;
  assign desc_addr = addr_q;
  assign rdata     = busy_q ? addr_q : AW'(DMA_SIGNATURE);

  p_busy_write_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr_en && !done) |=> (addr_q == $past(addr_q)));
  p_clear_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ((addr_q == '0) && !busy_q));
  p_launch_sets_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q);
endmodule

// File: rtl/cfg_dma_lane.sv
`timescale 1ns/1ps
module cfg_dma_lane #(
  parameter int DW = 32
) (
  input  logic [$clog2(DW/8)-1:0] addr_lo,
  input  logic [7:0]              data_byte,
  output logic [DW/8-1:0]         wstrb,
  output logic [DW-1:0]           wdata
);
  localparam int NB = DW / 8;

  for (genvar j = 0; j < NB; j++) begin : g_lane
    assign wstrb[NB-1-j]       = (addr_lo == j);
    assign wdata[8*j +: 8]     = data_byte;
  end
endmodule

// File: rtl/cfg_dma_seq.sv
`timescale 1ns/1ps
module cfg_dma_seq #(
  parameter int DW = 32,
  parameter int KW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2*DW-1:0]   desc_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [2*DW-1:0]   mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic [DW/8-1:0]   mem_wstrb,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [DW-1:0]     mem_rdata,
  output logic              sel_we,
  output logic [KW-1:0]     sel_key,
  output logic              off_we,
  output logic [DW-1:0]     off_next,
  input  logic [DW-1:0]     item_off,
  input  logic [DW-1:0]     item_len,
  input  logic [7:0]        item_byte,
  output logic              done
);
  import cfg_dma_pkg::*;
  localparam int AW = 2 * DW;
  localparam int NB = DW / 8;
  localparam int LB = $clog2(NB);

  dma_st_e       st_q, st_d;
  logic [1:0]    widx_q, widx_d;
  logic [DW-1:0] ctrl_q, ctrl_d, len_q, len_d, cnt_q, cnt_d;
  logic [AW-1:0] tgt_q, tgt_d;
  logic          err_q, err_d;

  logic          byte_valid;
  logic [7:0]    out_byte;
  logic [AW-1:0] copy_addr, fetch_addr;
  logic [DW:0]   off_sum;
  logic [DW-1:0] skip_off, cnt_inc;
  logic [NB-1:0] lane_wstrb;
  logic [DW-1:0] lane_wdata;

  assign byte_valid = item_off < item_len;
  assign out_byte   = byte_valid ? item_byte : 8'h00;
  assign copy_addr  = tgt_q + AW'(cnt_q);
  assign fetch_addr = desc_addr + (AW'(widx_q) << LB);
  assign off_sum    = {1'b0, item_off} + {1'b0, len_q};
  assign skip_off   = (off_sum > {1'b0, item_len}) ? item_len : off_sum[DW-1:0];
  assign cnt_inc    = cnt_q + 1'b1;
  assign sel_key    = ctrl_q[DW-1 -: KW];

  cfg_dma_lane #(.DW(DW)) u_lane (
    .addr_lo   (copy_addr[LB-1:0]),
    .data_byte (out_byte),
    .wstrb     (lane_wstrb),
    .wdata     (lane_wdata)
  );

  always_comb begin
    st_d = st_q;  widx_d = widx_q;  ctrl_d = ctrl_q;  len_d = len_q;
    tgt_d = tgt_q;  cnt_d = cnt_q;  err_d = err_q;
    mem_req = 1'b0;  mem_we = 1'b0;  mem_addr = '0;
    mem_wdata = '0;  mem_wstrb = '0;
    sel_we = 1'b0;  off_we = 1'b0;  off_next = item_off;  done = 1'b0;
    unique case (st_q)
      S_IDLE: if (start) begin
        st_d = S_FETCH;  widx_d = '0;  err_d = 1'b0;
      end
      S_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = fetch_addr;
        if (mem_ack) begin
          if (mem_err) begin
            err_d = 1'b1;  st_d = S_WB;
          end else begin
            case (widx_q)
              2'd0:    ctrl_d = mem_rdata;
              2'd1:    len_d  = mem_rdata;
              2'd2:    tgt_d[AW-1:DW] = mem_rdata;
              default: tgt_d[DW-1:0]  = mem_rdata;
            endcase
            if (widx_q == 2'd3) st_d = S_SEL;
            else                widx_d = widx_q + 2'd1;
          end
        end
      end
      S_SEL: begin
        sel_we = ctrl_q[CB_SEL];
        st_d   = S_DISP;
      end
      S_DISP: begin
        cnt_d = '0;
        if (ctrl_q[CB_READ]) begin
          st_d = (len_q == '0) ? S_WB : S_COPY;
        end else begin
          if (ctrl_q[CB_SKIP]) begin
            off_we   = 1'b1;
            off_next = skip_off;
          end
          st_d = S_WB;
        end
      end
      S_COPY: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = copy_addr;
        mem_wdata = lane_wdata;
        mem_wstrb = lane_wstrb;
        if (mem_ack) begin
          if (mem_err) begin
            err_d = 1'b1;  st_d = S_WB;
          end else begin
            off_we   = byte_valid;
            off_next = item_off + 1'b1;
            cnt_d    = cnt_inc;
            if (cnt_inc == len_q) st_d = S_WB;
          end
        end
      end
      S_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_addr;
        mem_wdata = {{(DW-1){1'b0}}, err_q};
        mem_wstrb = '1;
        if (mem_ack) begin
          done = 1'b1;  st_d = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  widx_q <= '0;  ctrl_q <= '0;  len_q <= '0;
      tgt_q <= '0;  cnt_q <= '0;  err_q <= 1'b0;
    end else begin
      st_q <= st_d;  widx_q <= widx_d;  ctrl_q <= ctrl_d;  len_q <= len_d;
      tgt_q <= tgt_d;  cnt_q <= cnt_d;  err_q <= err_d;
    end
  end

  p_req_held_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  p_offset_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    off_we |-> (off_next <= item_len));
  p_single_strobe_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_COPY) |-> ($countones(mem_wstrb) == 1));
  p_status_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WB) |-> ((mem_wdata[DW-1:1] == '0) && (mem_wstrb == '1)));
  p_no_stray_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_COPY && st_q != S_WB) |-> !(mem_req && mem_we));
  p_select_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we |=> !sel_we);
endmodule

// File: rtl/cfg_dma_engine.sv
`timescale 1ns/1ps
module cfg_dma_engine #(
  parameter int DW = 32,
  parameter int KW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_wr_low,
  input  logic [DW-1:0]     reg_wdata,
  output logic [2*DW-1:0]   reg_rdata,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [2*DW-1:0]   mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic [DW/8-1:0]   mem_wstrb,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [DW-1:0]     mem_rdata,
  output logic              sel_we,
  output logic [KW-1:0]     sel_key,
  output logic              off_we,
  output logic [DW-1:0]     off_next,
  input  logic [DW-1:0]     item_off,
  input  logic [DW-1:0]     item_len,
  input  logic [7:0]        item_byte
);
  localparam int AW = 2 * DW;

  logic          start, done;
  logic [AW-1:0] desc_addr;

  cfg_dma_regs #(.DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .wr_low    (reg_wr_low),
    .wdata     (reg_wdata),
    .done      (done),
    .start     (start),
    .busy      (busy),
    .desc_addr (desc_addr),
    .rdata     (reg_rdata)
  );

  cfg_dma_seq #(.DW(DW), .KW(KW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .desc_addr (desc_addr),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_wstrb (mem_wstrb),
    .mem_ack   (mem_ack),
    .mem_err   (mem_err),
    .mem_rdata (mem_rdata),
    .sel_we    (sel_we),
    .sel_key   (sel_key),
    .off_we    (off_we),
    .off_next  (off_next),
    .item_off  (item_off),
    .item_len  (item_len),
    .item_byte (item_byte),
    .done      (done)
  );
endmodule

// File: tb/cfg_dma_engine_bench.sv
`timescale 1ns/1ps
module cfg_dma_engine_bench;
  localparam logic [63:0] SIG = 64'h5145_4D55_2043_4647;
  localparam logic [7:0]  DESC = 8'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0, reg_wr_low = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        busy, mem_req, mem_we, mem_ack, mem_err;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [3:0]  mem_wstrb;
  logic        sel_we, off_we;
  logic [15:0] sel_key;
  logic [31:0] off_next, item_len;
  logic [7:0]  item_byte;

  logic [15:0] p_key;
  logic [31:0] p_off;
  logic [7:0]  mem [256];
  logic [1:0]  err_mode = 2'd0;
  logic [7:0]  err_word = 8'h00;
  logic [31:0] last_hi;
  int          wb_count;
  int          n_chk = 0, n_fail = 0, cyc = 0;
  logic [15:0] ekey = '0;
  logic [31:0] eoff = '0;

  always #10 clk = ~clk;

  function automatic logic [31:0] lenf(input logic [15:0] k);
    return {29'd0, k[2:0]} + 32'd2;
  endfunction
  function automatic logic [7:0] bytef(input logic [15:0] k, input logic [31:0] o);
    return 8'(k[7:0] * 8'd13 + o[7:0] * 8'd7 + 8'd5);
  endfunction

  assign item_len  = lenf(p_key);
  assign item_byte = bytef(p_key, p_off);

  cfg_dma_engine u_cfg_dma_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_low(reg_wr_low),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wstrb(mem_wstrb), .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .sel_we(sel_we), .sel_key(sel_key), .off_we(off_we), .off_next(off_next),
    .item_off(p_off), .item_len(item_len), .item_byte(item_byte)
  );

  // configuration port model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_key <= '0; p_off <= '0;
    end else if (sel_we) begin
      p_key <= sel_key; p_off <= '0;
    end else if (off_we) begin
      p_off <= off_next;
    end
  end

  // memory model: big-endian words, bit 31:24 is the lowest byte
  logic hit;
  always_comb begin
    hit = (mem_addr[7:2] == err_word[7:2]) &&
          ((err_mode == 2'd1 && !mem_we) || (err_mode == 2'd2 && mem_we));
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_err <= 1'b0; mem_rdata <= '0;
      last_hi <= '0; wb_count <= 0;
    end else begin
      if (mem_req && mem_ack && mem_we && !mem_err) begin
        for (int j = 0; j < 4; j++)
          if (mem_wstrb[3-j]) mem[{mem_addr[7:2], 2'(j)}] <= mem_wdata[31-8*j -: 8];
        if (mem_wstrb == 4'hF) wb_count <= wb_count + 1;
      end
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        mem_err <= hit;
        mem_rdata <= {mem[{mem_addr[7:2], 2'd0}], mem[{mem_addr[7:2], 2'd1}],
                      mem[{mem_addr[7:2], 2'd2}], mem[{mem_addr[7:2], 2'd3}]};
        if (!mem_we) last_hi <= mem_addr[63:32];
      end else begin
        mem_ack <= 1'b0; mem_err <= 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_word(input logic [7:0] a, input logic [31:0] w);
    mem[a] = w[31:24]; mem[a+8'd1] = w[23:16]; mem[a+8'd2] = w[15:8]; mem[a+8'd3] = w[7:0];
  endtask
  function automatic logic [31:0] get_word(input logic [7:0] a);
    return {mem[a], mem[a+8'd1], mem[a+8'd2], mem[a+8'd3]};
  endfunction

  task automatic put_desc(input logic [31:0] ctrl, input logic [31:0] len, input logic [7:0] tgt);
    put_word(DESC, ctrl); put_word(DESC + 8'd4, len);
    put_word(DESC + 8'd8, 32'd0); put_word(DESC + 8'd12, {24'd0, tgt});
    for (int a = 8'h40; a < 8'h60; a++) mem[a] = 8'hAA;
  endtask

  task automatic launch(input logic [31:0] hi, input logic wr_hi);
    @(negedge clk);
    if (wr_hi) begin
      reg_wr_en = 1'b1; reg_wr_low = 1'b0; reg_wdata = hi; @(negedge clk);
    end
    reg_wr_en = 1'b1; reg_wr_low = 1'b1; reg_wdata = {24'd0, DESC}; @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // successful operation with full model check
  task automatic run_op(input logic [31:0] ctrl, input logic [31:0] len,
                        input logic [7:0] tgt, input bit intrude, input string tag);
    logic [31:0] L, o0;
    int bad, guard_bad, wb0;
    put_desc(ctrl, len, tgt);
    wb0 = wb_count;
    launch(32'd0, 1'b0);
    if (intrude) begin
      repeat (3) @(negedge clk);
      chk("R3 address visible while busy", reg_rdata, {56'd0, DESC});
      reg_wr_en = 1'b1; reg_wr_low = 1'b0; reg_wdata = 32'hDEAD_0000; @(negedge clk);
      reg_wr_low = 1'b1; reg_wdata = 32'h0000_0080; @(negedge clk);
      reg_wr_en = 1'b0;
      chk("R12 busy write ignored", reg_rdata, {56'd0, DESC});
    end
    wait_idle();
    if (ctrl[3]) begin ekey = ctrl[31:16]; eoff = '0; end
    L = lenf(ekey); o0 = eoff;
    bad = 0; guard_bad = 0;
    if (ctrl[1]) begin
      for (int i = 0; i < int'(len); i++) begin
        logic [7:0] e;
        e = ((o0 + 32'(i)) < L) ? bytef(ekey, o0 + 32'(i)) : 8'h00;
        if (mem[tgt + 8'(i)] !== e) bad++;
      end
      eoff = ((o0 + len) > L) ? L : o0 + len;
    end else if (ctrl[2]) begin
      eoff = ((o0 + len) > L) ? L : o0 + len;
    end
    for (int a = 8'h40; a < 8'h60; a++)
      if ((!ctrl[1] || a < int'(tgt) || a >= int'(tgt) + int'(len)) && mem[a] !== 8'hAA) guard_bad++;
    chk({tag, " R6 R7 copied bytes"}, 64'(bad), 64'd0);
    chk({tag, " R8 R14 untouched bytes"}, 64'(guard_bad), 64'd0);
    chk({tag, " R10 status word"}, {32'd0, get_word(DESC)}, 64'd0);
    chk({tag, " R5 R7 R8 item key/offset"}, {16'd0, p_key, p_off}, {16'd0, ekey, eoff});
    chk({tag, " R12 one operation"}, 64'(wb_count - wb0), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", {63'd0, busy}, 64'd0);
    chk("R1 no request after reset", {63'd0, mem_req}, 64'd0);
    chk("R1 idle signature", reg_rdata, SIG);

    // R2: high half stored, launched by low write
    put_desc(32'h0, 32'd0, 8'h40);
    launch(32'h0000_0007, 1'b1);
    wait_idle();
    chk("R2 upper address used in fetch", {32'd0, last_hi}, 64'h7);
    chk("R10 R9 status after no-op", {32'd0, get_word(DESC)}, 64'd0);
    chk("R1 signature after completion", reg_rdata, SIG);
    // R3: register cleared, next low-only launch uses zero upper half
    put_desc(32'h0, 32'd0, 8'h40);
    launch(32'd0, 1'b0);
    wait_idle();
    chk("R3 upper half cleared", {32'd0, last_hi}, 64'h0);

    // R9: selection only, then a descriptor doing nothing
    run_op(32'h0003_0008, 32'd1, 8'h40, 1'b0, "R9 select only");
    run_op(32'h0000_000C, 32'd3, 8'h40, 1'b0, "R8 skip");
    run_op(32'h0000_0000, 32'd5, 8'h40, 1'b0, "R9 empty control");
    run_op(32'h0005_0008, 32'd0, 8'h40, 1'b0, "R5 R9 reselect");

    // near-exhaustive sweep: key, starting offset, length, alignment (R4 R6 R7 R14)
    for (int k = 0; k < 8; k++)
      for (int p = 0; p < 3; p++)
        for (int n = 0; n < 12; n++) begin
          run_op({16'(k), 16'h000C}, 32'(p), 8'h40, 1'b0, "R5 R8 sweep skip");
          run_op(32'h0000_0002, 32'(n), 8'h40 + 8'(n % 4), 1'b0, "R4 sweep read");
        end
    // read bit has priority over skip
    run_op(32'h0002_000E, 32'd4, 8'h41, 1'b0, "R6 read with skip");

    // R12: busy-time writes ignored
    run_op(32'h0006_000A, 32'd9, 8'h42, 1'b1, "R12 intrusion");

    // R11: fetch error on the length word
    put_desc(32'h0004_000A, 32'd4, 8'h40);
    err_mode = 2'd1; err_word = DESC + 8'd4;
    launch(32'd0, 1'b0); wait_idle(); err_mode = 2'd0;
    chk("R11 fetch error status", {32'd0, get_word(DESC)}, 64'd1);
    chk("R11 fetch error leaves item state", {16'd0, p_key, p_off}, {16'd0, ekey, eoff});

    // R11: copy error part way through
    run_op(32'h0007_0008, 32'd0, 8'h40, 1'b0, "R5 select key 7");
    put_desc(32'h0000_0002, 32'd8, 8'h44);
    err_mode = 2'd2; err_word = 8'h48;
    launch(32'd0, 1'b0); wait_idle(); err_mode = 2'd0;
    chk("R11 copy error status", {32'd0, get_word(DESC)}, 64'd1);
    chk("R11 copy error offset", {32'd0, p_off}, 64'd4);
    chk("R11 bytes before error", {32'd0, get_word(8'h44)},
        {32'd0, bytef(16'd7, 0), bytef(16'd7, 1), bytef(16'd7, 2), bytef(16'd7, 3)});
    chk("R11 R14 bytes after error", {32'd0, get_word(8'h48)}, 64'hAAAAAAAA);
    eoff = 32'd4;

    // R11: error on the status write
    put_desc(32'h0000_0004, 32'd2, 8'h40);
    err_mode = 2'd2; err_word = DESC;
    launch(32'd0, 1'b0); wait_idle(); err_mode = 2'd0;
    chk("R11 status write error leaves control", {32'd0, get_word(DESC)}, 64'h4);
    chk("R11 R8 skip done before status error", {32'd0, p_off}, 64'd6);
    chk("R11 idle after status error", {63'd0, busy}, 64'd0);
    eoff = 32'd6;

    run_op(32'h0000_0002, 32'd5, 8'h43, 1'b0, "R7 recovery read past end");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule